// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from values held in a small 32-bit register file. Two counters step through each line and each frame. Their positions are compared with separately programmed windows for the visible area, the blanking interval and the sync pulse. The results drive hsync, vsync, blank and a display-enable strobe, and the pixel column and row are exported for downstream pixel logic.

Software first opens the register file with a 16-bit key. It clears the run bit, writes the six timing words and sets the run bit again. Each timing word carries two 16-bit values, each stored as the real value minus one. Written timing values are held in a staging copy and are moved into the working copy only at a frame boundary. A frame that is already being scanned therefore never mixes old and new timing.

Top module: `raster_timing_gen`

## Requirements
- R1: Address 0 is the key register and reads as zero. Address 1 is control. Addresses 2, 3 and 4 are the horizontal span, blank and sync words, and addresses 5, 6 and 7 are the vertical span, blank and sync words. In each timing word, bits 15:0 hold the first value minus one and bits 31:16 hold the second value minus one. The span word pairs active with total. Reads return the staged value last written, at once and with no frame delay.
- R2: After reset the register file is locked. A write of 0x00004758 to address 0 unlocks it, and a write of any other value to address 0 locks it again. While locked, writes to addresses 1 to 7 are discarded and readback does not change.
- R3: Control bit 0 is run, bit 1 is graphics enable, bit 2 is video enable, bit 3 inverts hsync and bit 4 inverts vsync. Control bits take effect in the cycle after the write.
- R4: While running, pix_x counts 0, 1, ... up to total minus one and then returns to 0, with total taken from the horizontal span word.
- R5: pix_y advances by one on each pix_x wrap and returns to 0 after the row that equals the vertical total minus one.
- R6: blank is high while running when pix_x lies in [blank start, blank end) horizontally, or pix_y lies in [blank start, blank end) vertically.
- R7: Before inversion, hsync is high while running when pix_x lies in [sync start, sync end). vsync follows the same rule on pix_y. Each output is XORed with its own invert bit.
- R8: disp_en is high when run is set, at least one of graphics enable or video enable is set, and both pix_x and pix_y are below their active values.
- R9: In the cycle after run is cleared, pix_x and pix_y read 0, blank and disp_en are low, and each sync output sits at its inactive level (its invert bit). The counters stay at zero while run is clear.
- R10: Staged timing words reach the counters and comparators only at a frame start, which is the wrap of both counters, or in any cycle while run is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hsync | output | 1 | Horizontal sync, polarity set by control bit 3 |
| vsync | output | 1 | Vertical sync, polarity set by control bit 4 |
| blank | output | 1 | Blanking interval, active high |
| disp_en | output | 1 | Visible-area data enable |
| pix_x | output | CW (12) | Current column |
| pix_y | output | CW (12) | Current row |

## Verification
The assertions check three things on every cycle. Locked writes never alter the register file. The working timing copy moves only at a frame start. Each counter either steps by one, wraps at its total or sits at zero while stopped. The bench's scenarios are needed for the rest. It compares every output against an arithmetic model through whole frames, across several control patterns and both sync polarities. It also checks that a mid-frame rewrite leaves the current frame at its old line length and gives the next frame the new one.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int unsigned FW = 16;

   typedef struct packed {
      logic [FW-1:0] second;
      logic [FW-1:0] first;
   } pair_t;

   typedef struct packed {
      pair_t sync;
      pair_t blank;
      pair_t span;
   } axis_cfg_t;

   localparam logic [2:0] ADDR_KEY  = 3'd0;
   localparam logic [2:0] ADDR_CTRL = 3'd1;
   localparam logic [2:0] ADDR_H0   = 3'd2;
   localparam logic [2:0] ADDR_V0   = 3'd5;

   localparam int unsigned C_RUN  = 0;
   localparam int unsigned C_GFX  = 1;
   localparam int unsigned C_VID  = 2;
   localparam int unsigned C_HINV = 3;
   localparam int unsigned C_VINV = 4;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
   import rtg_pkg::*;
#(
   parameter logic [15:0] KEY = 16'h4758
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             frame_start,
   output logic [4:0]       ctrl,
   output axis_cfg_t        h_cfg,
   output axis_cfg_t        v_cfg
);
   localparam int unsigned NREG = 8;

   logic [NREG-1:0][31:0] regs;
   logic                  unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         regs     <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_KEY)
            unlocked <= (bus_wdata == {16'h0000, KEY});
         else if (unlocked)
            regs[bus_addr] <= bus_wdata;
      end
   end

   // working copies follow the staging words only at frame boundaries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cfg <= '0;
         v_cfg <= '0;
      end else if (frame_start) begin
         h_cfg <= {regs[ADDR_H0+3'd2], regs[ADDR_H0+3'd1], regs[ADDR_H0]};
         v_cfg <= {regs[ADDR_V0+3'd2], regs[ADDR_V0+3'd1], regs[ADDR_V0]};
      end
   end

   assign ctrl      = regs[ADDR_CTRL][4:0];
   assign bus_rdata = (bus_addr == ADDR_KEY) ? 32'h0 : regs[bus_addr];

   assert_locked_drop_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked && bus_addr != ADDR_KEY) |=> (regs == $past(regs)));

   assert_key_opens_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_KEY && bus_wdata == {16'h0000, KEY}) |=> unlocked);

   assert_frame_update_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(h_cfg) || !$stable(v_cfg)) |-> $past(frame_start));
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int unsigned CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  axis_cfg_t     cfg,
   output logic [CW-1:0] cnt,
   output logic          wrap,
   output logic          in_span,
   output logic          in_blank,
   output logic          in_sync
);
   localparam logic [FW-1:0] CMAX = FW'((32'd1 << CW) - 32'd1);

   logic [FW-1:0] pos;
   assign pos = FW'(cnt);

   assign wrap = step && (pos >= cfg.span.second);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (step)   cnt <= wrap ? '0 : cnt + 1'b1;
   end

   // stored minus-one: pos >= start  <=>  pos > start_m1 ; pos < end  <=>  pos <= end_m1
   assign in_span  = (pos <= cfg.span.first);
   assign in_blank = (pos > cfg.blank.first) && (pos <= cfg.blank.second);
   assign in_sync  = (pos > cfg.sync.first)  && (pos <= cfg.sync.second);

   // R4 for the column counter, R5 for the row counter
   assert_count_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && cfg.span.second <= CMAX) |-> (pos <= cfg.span.second));

   assert_count_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && !wrap) |=> (cnt == $past(cnt) + 1'b1));

   assert_stop_clears_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int unsigned CW  = 12,
   parameter logic [15:0] KEY = 16'h4758
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [2:0]    bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          hsync,
   output logic          vsync,
   output logic          blank,
   output logic          disp_en,
   output logic [CW-1:0] pix_x,
   output logic [CW-1:0] pix_y
);
   if (CW < 2 || CW > FW) begin : g_cw_check
      $error("raster_timing_gen: CW must lie in 2..16");
   end

   logic [4:0]    ctrl;
   axis_cfg_t     h_cfg, v_cfg;
   logic          frame_start;
   logic          run;
   logic [CW-1:0] h_cnt, v_cnt;
   logic          h_wrap, v_wrap;
   logic          h_span, v_span, h_blk, v_blk, h_syn, v_syn;

   assign run         = ctrl[C_RUN];
   assign frame_start = !run || (h_wrap && v_wrap);

   rtg_regfile #(.KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .frame_start(frame_start),
      .ctrl(ctrl), .h_cfg(h_cfg), .v_cfg(v_cfg)
   );

   rtg_axis #(.CW(CW)) u_col (
      .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .cfg(h_cfg),
      .cnt(h_cnt), .wrap(h_wrap), .in_span(h_span), .in_blank(h_blk), .in_sync(h_syn)
   );

   rtg_axis #(.CW(CW)) u_row (
      .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap), .cfg(v_cfg),
      .cnt(v_cnt), .wrap(v_wrap), .in_span(v_span), .in_blank(v_blk), .in_sync(v_syn)
   );

   assign pix_x   = run ? h_cnt : '0;
   assign pix_y   = run ? v_cnt : '0;
   assign hsync   = ctrl[C_HINV] ^ (run & h_syn);
   assign vsync   = ctrl[C_VINV] ^ (run & v_syn);
   assign blank   = run & (h_blk | v_blk);
   assign disp_en = run & (ctrl[C_GFX] | ctrl[C_VID]) & h_span & v_span;
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
   localparam int unsigned CW = 12;
   localparam logic [31:0] KEYW = 32'h0000_4758;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          hsync, vsync, blank, disp_en;
   logic [CW-1:0] pix_x, pix_y;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_reg [8];
   logic [31:0] m_act [8];
   int          hx = 0, vy = 0;
   bit          m_unl = 1'b0;

   always #5 clk = ~clk;

   raster_timing_gen #(.CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync),
      .blank(blank), .disp_en(disp_en), .pix_x(pix_x), .pix_y(pix_y)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit inwin(int p, logic [31:0] w);
      return (p >= int'(w[15:0]) + 1) && (p < int'(w[31:16]) + 1);
   endfunction

   task automatic check_all();
      bit run = m_reg[1][0];
      bit hs  = run && inwin(hx, m_act[4]);
      bit vs  = run && inwin(vy, m_act[7]);
      bit bl  = run && (inwin(hx, m_act[3]) || inwin(vy, m_act[6]));
      bit de  = run && (m_reg[1][1] || m_reg[1][2]) &&
                hx < int'(m_act[2][15:0]) + 1 && vy < int'(m_act[5][15:0]) + 1;
      chk("R4 pix_x", 32'(pix_x), run ? hx : 0);
      chk("R5 pix_y", 32'(pix_y), run ? vy : 0);
      chk("R6 blank", 32'(blank), 32'(bl));
      chk("R7 hsync", 32'(hsync), 32'(hs ^ m_reg[1][3]));
      chk("R7 vsync", 32'(vsync), 32'(vs ^ m_reg[1][4]));
      chk("R8 disp_en", 32'(disp_en), 32'(de));
   endtask

   // model of one clock edge: counters use pre-edge state, then the write lands
   task automatic tick();
      bit run = m_reg[1][0];
      bit fs  = 1'b0;
      int ht  = int'(m_act[2][31:16]);
      int vt  = int'(m_act[5][31:16]);
      @(negedge clk);
      if (run) begin
         if (hx >= ht) begin
            hx = 0;
            if (vy >= vt) begin vy = 0; fs = 1'b1; end
            else vy++;
         end else hx++;
      end else begin
         hx = 0; vy = 0; fs = 1'b1;
      end
      if (fs) for (int i = 2; i < 8; i++) m_act[i] = m_reg[i];
      if (bus_wr) begin
         if (bus_addr == 3'd0) m_unl = (bus_wdata == KEYW);
         else if (m_unl) m_reg[bus_addr] = bus_wdata;
      end
      check_all();
   endtask

   task automatic wr(int addr, logic [31:0] data);
      bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, int addr, logic [31:0] exp);
      bus_addr = 3'(addr);
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(1_000_000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int mx;
      for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_act[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk("R9 reset pix_x", 32'(pix_x), 0);
      chk("R9 reset blank", 32'(blank), 0);
      chk("R9 reset hsync", 32'(hsync), 0);
      chk("R8 reset disp_en", 32'(disp_en), 0);
      for (int a = 0; a < 8; a++) rd_chk("R1 reset read", a, 32'h0);

      // locked register file drops writes
      wr(2, 32'h1111_2222);
      rd_chk("R2 locked drop", 2, 32'h0);

      // unlock and program a 10x7 raster
      wr(0, KEYW);
      wr(2, 32'h0009_0005); wr(3, 32'h0009_0005); wr(4, 32'h0008_0006);
      wr(5, 32'h0006_0003); wr(6, 32'h0006_0003); wr(7, 32'h0005_0004);
      rd_chk("R1 read hspan", 2, 32'h0009_0005);
      rd_chk("R1 read hsync", 4, 32'h0008_0006);
      rd_chk("R1 read vsync", 7, 32'h0005_0004);
      rd_chk("R1 key reads zero", 0, 32'h0);

      // wrong key relocks
      wr(0, 32'h0000_1234);
      wr(2, 32'hDEAD_BEEF);
      rd_chk("R2 relocked", 2, 32'h0009_0005);
      wr(0, KEYW);

      // run with graphics enable, two full frames plus margin
      wr(1, 32'h0000_0003);
      rd_chk("R3 ctrl read", 1, 32'h0000_0003);
      repeat (145) tick();

      // stop: everything idle one clock later
      wr(1, 32'h0000_0002);
      chk("R9 stop pix_x", 32'(pix_x), 0);
      chk("R9 stop pix_y", 32'(pix_y), 0);
      chk("R9 stop blank", 32'(blank), 0);
      chk("R9 stop disp_en", 32'(disp_en), 0);
      chk("R9 stop hsync", 32'(hsync), 0);
      repeat (5) tick();
      chk("R9 held pix_x", 32'(pix_x), 0);

      // inverted syncs, no data enables
      wr(1, 32'h0000_0019);
      repeat (75) tick();
      wr(1, 32'h0000_0018);
      chk("R3 idle hsync inactive inverted", 32'(hsync), 1);
      chk("R3 idle vsync inactive inverted", 32'(vsync), 1);

      // video enable only, then rewrite line length mid-frame
      wr(1, 32'h0000_0005);
      while (!(pix_y == 2 && pix_x == 3)) tick();
      wr(2, 32'h000B_0005);
      wr(3, 32'h000B_0005);
      rd_chk("R1 staged read", 2, 32'h000B_0005);
      mx = 0;
      while (!(pix_x == 0 && pix_y == 0)) begin
         if (int'(pix_x) > mx) mx = int'(pix_x);
         tick();
      end
      chk("R10 old line length kept", 32'(mx), 9);
      mx = 0;
      tick();
      while (!(pix_x == 0 && pix_y == 0)) begin
         if (int'(pix_x) > mx) mx = int'(pix_x);
         tick();
      end
      chk("R10 new line length next frame", 32'(mx), 11);
      repeat (10) tick();
      finish_run();
   end
endmodule